// File: doc/BRIEF.md
# Packed Lane Shifter with Rounding and Saturation

This block shifts every lane of a 32-bit packed operand independently. It supports three shift kinds: arithmetic right, logical right and logical left. Each lane's shift amount comes either from the same lane of a second operand or from a shared immediate. A mode field chooses between two behaviours. In plain mode the shift simply truncates. In the other mode, right shifts round to nearest by adding back the last bit shifted out, and left shifts clamp to the lane's representable range instead of wrapping.

The register index of the operands selects the lane geometry and signedness:

- Indices 2 to 15 select four byte lanes.
- Indices 16 to 29 select two halfword lanes.
- In each of those ranges, the lower half is signed and the upper half is unsigned.

A datapath issues one operation per cycle with a valid strobe. The result and a saturation flag appear one cycle later with their own valid strobe.

Top module: `simd_shift_unit`

## Requirements
- R1: Operation select op_i: 00 arithmetic right (sign fill), 01 logical right (zero fill), 10 logical left, 11 pass the operand through unchanged. With imm_sel_i=0, each lane's amount is the low 3 bits (byte lanes) or low 4 bits (halfword lanes) of the same lane of b_i.
- R2: With imm_sel_i=1, every lane uses imm_i as its amount. Byte lanes use only imm_i[2:0]. Halfword lanes use all of imm_i[3:0].
- R3: Register index idx_i selects the lane format. Indices 2–7 are signed bytes, 8–15 unsigned bytes, 16–23 signed halfwords and 24–29 unsigned halfwords. Lane k occupies bits [w*k+w-1 : w*k] of width w, and lanes never interact.
- R4: Mode 00 is a plain shift. Left shifts drop the bits carried out, and sat_o is 0.
- R5: In mode 01, right shifts round: the result is the truncated shift plus the most significant bit shifted out. An amount of zero returns the lane unchanged.
- R6: In mode 01, a left shift that overflows clamps the lane. Signed formats clamp to their maximum (0x7F or 0x7FFF) or minimum (0x80 or 0x8000) by the sign of the input; unsigned formats clamp to all ones. sat_o is 1 when any lane clamps.
- R7: Modes 10 and 11 behave exactly as mode 00.
- R8: Indices 0, 1, 30 and 31 produce a zero result and sat_o=0.
- R9: valid_o follows valid_i one cycle later. result_o and sat_o update only on a valid input and hold their value otherwise.
- R10: While rst_ni is low, result_o, sat_o and valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Shift kind |
| imm_sel_i | input | 1 | 1: amount from imm_i, 0: from b_i lanes |
| mode_i | input | 2 | 01 rounding/saturating, others plain |
| idx_i | input | 5 | Register index selecting lane format |
| a_i | input | 32 | Packed operand to shift |
| b_i | input | 32 | Packed per-lane shift amounts |
| imm_i | input | 4 | Immediate shift amount |
| result_o | output | 32 | Shifted packed result |
| sat_o | output | 1 | Some lane clamped |
| valid_o | output | 1 | Result strobe |

## Verification
A fault in the lane datapath or the format decode shows as a wrong result_o one cycle after the offending valid_i. Each operation is checked independently, so a single bad vector exposes it. A rounding bit or a saturation clamp taken from the wrong position only shows for amounts and lane values near the edges. For that reason, random vectors are mixed with directed vectors at amount zero, at the maximum amount and at the signed limits. A fault in the hold logic shows only on idle cycles, as result_o changing while valid_o is low.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;
  typedef enum logic [1:0] {
    SH_SRA  = 2'b00,
    SH_SRL  = 2'b01,
    SH_SLL  = 2'b10,
    SH_PASS = 2'b11
  } sh_op_e;

  localparam logic [1:0] MODE_RS = 2'b01;

  typedef struct packed {
    logic ok;
    logic half;
    logic sgn;
  } lane_fmt_t;
endpackage

// File: rtl/simd_shift_fmt_dec.sv
module simd_shift_fmt_dec
  import simd_shift_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  output lane_fmt_t        fmt_o
);
  localparam int B_LO = 2, BU_LO = 8, H_LO = 16, HU_LO = 24, H_HI = 29;

  always_comb begin
    fmt_o.ok   = (int'(idx_i) >= B_LO) && (int'(idx_i) <= H_HI);
    fmt_o.half = int'(idx_i) >= H_LO;
    fmt_o.sgn  = fmt_o.half ? (int'(idx_i) < HU_LO) : (int'(idx_i) < BU_LO);
  end
endmodule

// File: rtl/simd_shift_lane.sv
module simd_shift_lane
  import simd_shift_pkg::*;
#(
  parameter int LW = 8,
  localparam int SW = $clog2(LW)
) (
  input  logic [LW-1:0] x_i,
  input  logic [SW-1:0] amt_i,
  input  sh_op_e        op_i,
  input  logic          rs_i,
  input  logic          sgn_i,
  output logic [LW-1:0] res_o,
  output logic          sat_o
);
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  logic [LW-1:0] sra_v, srl_v, shl_v, back_v, rnd_v;
  logic          last_out, ovf;

  always_comb begin
    sra_v    = LW'($signed(x_i) >>> amt_i);
    srl_v    = x_i >> amt_i;
    last_out = (amt_i == '0) ? 1'b0 : x_i[amt_i - 1'b1];
    rnd_v    = {{(LW-1){1'b0}}, last_out & rs_i};
    shl_v    = x_i << amt_i;
    // overflow if shifting back does not restore the operand
    back_v   = sgn_i ? LW'($signed(shl_v) >>> amt_i) : (shl_v >> amt_i);
    ovf      = back_v != x_i;
    sat_o    = 1'b0;
    unique case (op_i)
      SH_SRA: res_o = sra_v + rnd_v;
      SH_SRL: res_o = srl_v + rnd_v;
      SH_SLL: begin
        if (rs_i && ovf) begin
          sat_o = 1'b1;
          res_o = sgn_i ? (x_i[LW-1] ? SMIN : SMAX) : '1;
        end else begin
          res_o = shl_v;
        end
      end
      default: res_o = x_i;
    endcase
  end
endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
  import simd_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 4,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              imm_sel_i,
  input  logic [1:0]        mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              sat_o,
  output logic              valid_o
);
  localparam int BW  = 8;
  localparam int HW  = 16;
  localparam int NB  = DATA_W / BW;
  localparam int NH  = DATA_W / HW;
  localparam int BSW = $clog2(BW);
  localparam int HSW = $clog2(HW);

  lane_fmt_t         fmt;
  sh_op_e            op;
  logic              rs;
  logic [DATA_W-1:0] byte_res, half_res, res_d;
  logic [NB-1:0]     byte_sat;
  logic [NH-1:0]     half_sat;
  logic              sat_d;

  assign op = sh_op_e'(op_i);
  assign rs = (mode_i == MODE_RS);

  simd_shift_fmt_dec #(.IDX_W(IDX_W)) u_dec (
    .idx_i (idx_i),
    .fmt_o (fmt)
  );

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BSW-1:0] amt;
    assign amt = imm_sel_i ? imm_i[BSW-1:0] : b_i[g*BW +: BSW];
    simd_shift_lane #(.LW(BW)) u_lane (
      .x_i   (a_i[g*BW +: BW]),
      .amt_i (amt),
      .op_i  (op),
      .rs_i  (rs),
      .sgn_i (fmt.sgn),
      .res_o (byte_res[g*BW +: BW]),
      .sat_o (byte_sat[g])
    );
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    logic [HSW-1:0] amt;
    assign amt = imm_sel_i ? imm_i[HSW-1:0] : b_i[g*HW +: HSW];
    simd_shift_lane #(.LW(HW)) u_lane (
      .x_i   (a_i[g*HW +: HW]),
      .amt_i (amt),
      .op_i  (op),
      .rs_i  (rs),
      .sgn_i (fmt.sgn),
      .res_o (half_res[g*HW +: HW]),
      .sat_o (half_sat[g])
    );
  end

  always_comb begin
    if (!fmt.ok) begin
      res_d = '0;
      sat_d = 1'b0;
    end else if (fmt.half) begin
      res_d = half_res;
      sat_d = |half_sat;
    end else begin
      res_d = byte_res;
      sat_d = |byte_sat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      sat_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        sat_o    <= sat_d;
      end
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i && rst_ni));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(sat_o));

  // R4
  sat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !(op_i == 2'b10 && mode_i == MODE_RS) |=> !sat_o);

  // R8
  bad_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (idx_i < 2 || idx_i > 29) |=> result_o == '0 && !sat_o);

  // R6
  sat_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fmt.ok && !fmt.half && fmt.sgn && byte_sat[0]
      |=> result_o[7:0] == 8'h7F || result_o[7:0] == 8'h80);
endmodule

// File: tb/simd_shift_unit_tb.sv
module simd_shift_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [4:0]  idx_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [3:0]  imm_i = '0;
  logic [31:0] result_o;
  logic        sat_o;
  logic        valid_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_shift_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .imm_sel_i(imm_sel_i), .mode_i(mode_i), .idx_i(idx_i), .a_i(a_i),
    .b_i(b_i), .imm_i(imm_i), .result_o(result_o), .sat_o(sat_o),
    .valid_o(valid_o)
  );

  function automatic logic [31:0] model(input logic [1:0] op, input logic is,
      input logic [1:0] md, input logic [4:0] idx, input logic [31:0] a,
      input logic [31:0] b, input logic [3:0] im, output logic sat);
    int w, amt;
    bit sg;
    longint x, xs, full, hi, lo, umax, rv;
    logic [31:0] r;
    sat = 1'b0;
    r = '0;
    if (idx < 2 || idx > 29) return r;
    w    = (idx >= 16) ? 16 : 8;
    sg   = (idx <= 7) || (idx >= 16 && idx <= 23);
    umax = (longint'(1) << w) - 1;
    hi   = (longint'(1) << (w - 1)) - 1;
    lo   = -(hi + 1);
    for (int l = 0; l < 32 / w; l++) begin
      x  = longint'(a >> (l * w)) & umax;
      xs = (x > hi) ? x - (umax + 1) : x;
      amt = is ? int'(im) % w : int'((b >> (l * w)) % w);
      case (op)
        2'b00: begin
          rv = xs >>> amt;
          if (md == 2'b01 && amt > 0) rv += (xs >>> (amt - 1)) & 1;
        end
        2'b01: begin
          rv = x >> amt;
          if (md == 2'b01 && amt > 0) rv += (x >> (amt - 1)) & 1;
        end
        2'b10: begin
          full = (sg ? xs : x) * (longint'(1) << amt);
          rv = full;
          if (md == 2'b01) begin
            if (sg && full > hi) begin rv = hi; sat = 1'b1; end
            else if (sg && full < lo) begin rv = lo; sat = 1'b1; end
            else if (!sg && full > umax) begin rv = umax; sat = 1'b1; end
          end
        end
        default: rv = x;
      endcase
      r |= 32'(rv & umax) << (l * w);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] op, input logic is,
      input logic [1:0] md, input logic [4:0] idx, input logic [31:0] a,
      input logic [31:0] b, input logic [3:0] im);
    logic [31:0] exp;
    logic esat;
    @(negedge clk_i);
    op_i = op; imm_sel_i = is; mode_i = md; idx_i = idx;
    a_i = a; b_i = b; imm_i = im; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    exp = model(op, is, md, idx, a, b, im, esat);
    check({tag, " result"}, result_o, exp);
    check({tag, " sat"}, {31'b0, sat_o}, {31'b0, esat});
    check({tag, " valid R9"}, {31'b0, valid_o}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk_i);
    // R10
    check("R10 reset result", result_o, 32'h0);
    check("R10 reset flags", {30'b0, sat_o, valid_o}, 32'h0);
    rst_ni = 1'b1;

    run("R4 sra byte signed", 2'b00, 1'b0, 2'b00, 5'd3, 32'h80F0_7F11, 32'h0701_0302, 4'd0);
    run("R1 srl half", 2'b01, 1'b0, 2'b00, 5'd25, 32'h8001_FFFF, 32'h000F_0004, 4'd0);
    run("R4 sll wrap", 2'b10, 1'b0, 2'b00, 5'd3, 32'h40C0_017F, 32'h0101_0101, 4'd0);
    run("R6 sll sat signed byte", 2'b10, 1'b0, 2'b01, 5'd3, 32'h40C0_017F, 32'h0101_0101, 4'd0);
    run("R6 sll sat neg half", 2'b10, 1'b1, 2'b01, 5'd20, 32'hC000_0001, 32'h0, 4'd2);
    run("R6 sll sat unsigned byte", 2'b10, 1'b1, 2'b01, 5'd10, 32'h8001_7F20, 32'h0, 4'd3);
    run("R6 sll no sat edge", 2'b10, 1'b1, 2'b01, 5'd28, 32'h7FFF_0001, 32'h0, 4'd0);
    run("R5 round sra", 2'b00, 1'b0, 2'b01, 5'd18, 32'hFFFB_0006, 32'h0001_0002, 4'd0);
    run("R5 round srl byte", 2'b01, 1'b1, 2'b01, 5'd12, 32'hFF03_0180, 32'h0, 4'd1);
    run("R5 zero amount", 2'b00, 1'b0, 2'b01, 5'd4, 32'h8182_FF01, 32'h0808_1000, 4'd0);
    run("R2 imm byte masks bit3", 2'b01, 1'b1, 2'b00, 5'd9, 32'hF0F0_F0F0, 32'h0707_0707, 4'd9);
    run("R2 imm half full", 2'b00, 1'b1, 2'b00, 5'd17, 32'h8000_7FFF, 32'h0, 4'd15);
    run("R7 mode 10 plain", 2'b10, 1'b1, 2'b10, 5'd3, 32'h7F7F_7F7F, 32'h0, 4'd4);
    run("R7 mode 11 plain", 2'b00, 1'b1, 2'b11, 5'd16, 32'h0003_0003, 32'h0, 4'd1);
    run("R1 pass op", 2'b11, 1'b0, 2'b01, 5'd27, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 4'd7);
    run("R8 idx 1", 2'b10, 1'b1, 2'b01, 5'd1, 32'h7F7F_7F7F, 32'h0, 4'd5);
    run("R8 idx 30", 2'b01, 1'b0, 2'b00, 5'd30, 32'hFFFF_FFFF, 32'h0, 4'd0);
    run("R3 idx 15 unsigned byte", 2'b10, 1'b1, 2'b01, 5'd15, 32'h0102_4080, 32'h0, 4'd1);
    run("R3 idx 29 unsigned half", 2'b10, 1'b1, 2'b01, 5'd29, 32'h4000_8000, 32'h0, 4'd1);

    // R9 hold while idle
    run("R9 setup", 2'b01, 1'b0, 2'b00, 5'd9, 32'h1234_5678, 32'h0102_0304, 4'd0);
    held = result_o;
    @(negedge clk_i);
    a_i = 32'hFFFF_FFFF; op_i = 2'b10; mode_i = 2'b01; imm_sel_i = 1'b1; imm_i = 4'd7;
    repeat (2) @(negedge clk_i);
    check("R9 hold result", result_o, held);
    check("R9 idle valid", {31'b0, valid_o}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [4:0] idx;
      idx = ($urandom % 8 == 0) ? 5'($urandom) : 5'(2 + $urandom % 28);
      run("R1/R3 random", 2'($urandom), 1'($urandom), 2'($urandom), idx,
          $urandom, $urandom, 4'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule